// File: doc/BRIEF.md
# DMA Channel Start/Halt Control

This block is the control and status core of a single DMA channel. Software reaches it through a plain register bus: a write strobe, a word address, write data, and combinational read data. The block holds the channel's mode settings, its status flags and four address registers. It turns register writes into start, halt, resume, continue and abort actions. Toward the data mover it gives a one-cycle start pulse, a one-cycle abort pulse and a run level. The data mover reports back with done, descriptor-fetched, error and end-of-segment/link/list event inputs.

The channel runs in one of two modes. In direct mode, software loads the source and destination addresses itself. In chaining mode, the mover walks descriptors starting from a link-descriptor address, or from a list-descriptor address when extended chaining is selected. A single-write start option lets one write to the proper address register launch the transfer with no separate write to the mode register.

Top module: `dma_chan_ctrl`

## Requirements
- R1: When a mode-register write takes the start bit from 0 to 1 while the channel is idle, `busy` and `mv_run` are high on the next cycle and `mv_start` pulses high for exactly one cycle. A `mv_done` pulse while busy returns the channel to idle and clears the start bit.
- R2: Writing start=0 while busy halts the channel. `mv_run` goes low, while busy stays set and the halted status bit is set. Writing start=1 again resumes the transfer with `mv_run` high and no new `mv_start` pulse. Writing start=0 while idle leaves the status unchanged.
- R3: A mode write with the abort bit set while busy pulses `mv_abort` for one cycle and clears both busy and start. With the channel idle, the abort bit has no effect. The abort bit always reads back as 0.
- R4: Encoding. The mode register is at offset 0: bit0 start, bit1 abort, bit2 direct (1 = direct, 0 = chaining), bit3 continue, bit4 single-write enable, bit5 select, bit6 extended chaining. The status register is at offset 1: bit0 busy, bit1 halted, bit2 transfer error, bit3 programming error, bit4 end-of-links, bit5 end-of-segment, bit6 end-of-list. Offsets 2 to 5 hold the source, destination, link-descriptor and list-descriptor addresses. `desc_addr` shows the list address when extended chaining is on, and the link address when it is off.
- R5: `mv_cont` follows the stored continue bit. A `mv_desc_fetched` pulse clears it.
- R6: In direct mode with single-write enabled and the channel idle, a write to the source register starts the channel when select=1. When select=0, a write to the destination register starts it instead. A write to the other address register does not start the channel.
- R7: In chaining mode with single-write enabled and the channel idle, a write to the link-descriptor register starts the channel when extended chaining is off. When it is on, a write to the list-descriptor register starts it. A write to the other descriptor register does not start the channel.
- R8: A write to the single-write trigger register while busy only updates that address. It produces no `mv_start`, and busy and start keep their values.
- R9: A mode write that sets continue together with direct, or sets select with single-write disabled, is discarded as a whole. It sets the programming-error flag and does not start the channel.
- R10: After reset the status reads all zeros and the mode reads zero. The error and event flags clear when 1 is written to them. When a hardware set and a clearing write hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA | Register word offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| mv_start | output | 1 | One-cycle pulse: begin a new transfer |
| mv_abort | output | 1 | One-cycle pulse: drop the current transfer |
| mv_run | output | 1 | Channel busy and not halted |
| mv_cont | output | 1 | Continue from the current descriptor |
| mv_direct | output | 1 | 1 = direct mode, 0 = chaining mode |
| src_addr | output | AW | Source address register |
| dst_addr | output | AW | Destination address register |
| desc_addr | output | AW | Selected descriptor start address |
| mv_done | input | 1 | Transfer finished |
| mv_desc_fetched | input | 1 | First descriptor has been read |
| mv_err | input | 1 | Transfer error event |
| ev_link_end | input | 1 | End-of-links event |
| ev_seg_end | input | 1 | End-of-segment event |
| ev_list_end | input | 1 | End-of-list event |

## Verification
The assertions assume the data mover pulses `mv_done` only while the channel is busy. They also assume `mv_desc_fetched` arrives only after a chaining start. Neither pulse is expected in the same cycle as a mode-register write, because the done and write priorities are not what the properties describe. The stimulus keeps every mover pulse on a cycle of its own, apart from register writes. Only the flag-collision test deliberately lines up an error event with a clearing write, to check that the hardware set wins.

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int AW = 32,
  parameter int RA = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [RA-1:0] reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          mv_start,
  output logic          mv_abort,
  output logic          mv_run,
  output logic          mv_cont,
  output logic          mv_direct,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] desc_addr,
  input  logic          mv_done,
  input  logic          mv_desc_fetched,
  input  logic          mv_err,
  input  logic          ev_link_end,
  input  logic          ev_seg_end,
  input  logic          ev_list_end
);
  localparam logic [RA-1:0] OFF_MODE = RA'(0);
  localparam logic [RA-1:0] OFF_STAT = RA'(1);
  localparam logic [RA-1:0] OFF_SRC  = RA'(2);
  localparam logic [RA-1:0] OFF_DST  = RA'(3);
  localparam logic [RA-1:0] OFF_LINK = RA'(4);
  localparam logic [RA-1:0] OFF_LIST = RA'(5);
  localparam int NFLAG = 5;
  localparam int FLAG_LSB = 2;

  logic st_q, dir_q, cont_q, sws_q, sel_q, ext_q, busy_q;
  logic [NFLAG-1:0] flags_q, flags_d, hw_set, sw_clr;
  logic [AW-1:0] src_q, dst_q, link_q, list_q;
  logic st_d, busy_d, cont_d, start_p, abort_p;

  wire w_start = reg_wdata[0];
  wire w_abort = reg_wdata[1];
  wire w_dir   = reg_wdata[2];
  wire w_cont  = reg_wdata[3];
  wire w_sws   = reg_wdata[4];
  wire w_sel   = reg_wdata[5];
  wire w_ext   = reg_wdata[6];

  wire wr_mode  = reg_we && reg_addr == OFF_MODE;
  wire wr_stat  = reg_we && reg_addr == OFF_STAT;
  wire perr_req = wr_mode && ((w_cont && w_dir) || (w_sel && !w_sws));
  wire mode_ok  = wr_mode && !perr_req;

  wire [RA-1:0] trig_off = dir_q ? (sel_q ? OFF_SRC : OFF_DST)
                                 : (ext_q ? OFF_LIST : OFF_LINK);
  wire sws_hit = reg_we && sws_q && reg_addr == trig_off && !busy_q;

  always_comb begin
    busy_d  = busy_q;
    st_d    = st_q;
    start_p = 1'b0;
    abort_p = 1'b0;
    if (busy_q && mv_done) begin
      busy_d = 1'b0;
      st_d   = 1'b0;
    end
    if (mode_ok) begin
      if (w_abort && busy_q) begin
        busy_d  = 1'b0;
        st_d    = 1'b0;
        abort_p = 1'b1;
      end else begin
        if (w_start && !st_q && !busy_q) begin
          busy_d  = 1'b1;
          start_p = 1'b1;
        end
        st_d = w_start && busy_d;
      end
    end else if (sws_hit) begin
      busy_d  = 1'b1;
      st_d    = 1'b1;
      start_p = 1'b1;
    end
  end

  always_comb begin
    cont_d = cont_q;
    if (mv_desc_fetched) cont_d = 1'b0;
    if (mode_ok) cont_d = w_cont;
  end

  assign hw_set  = {ev_list_end, ev_seg_end, ev_link_end, perr_req, mv_err};
  assign sw_clr  = wr_stat ? reg_wdata[FLAG_LSB +: NFLAG] : '0;
  assign flags_d = (flags_q & ~sw_clr) | hw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= 1'b0; dir_q <= 1'b0; cont_q <= 1'b0; sws_q <= 1'b0;
      sel_q <= 1'b0; ext_q <= 1'b0; busy_q <= 1'b0;
      flags_q <= '0;
      mv_start <= 1'b0; mv_abort <= 1'b0;
      src_q <= '0; dst_q <= '0; link_q <= '0; list_q <= '0;
    end else begin
      st_q     <= st_d;
      busy_q   <= busy_d;
      cont_q   <= cont_d;
      flags_q  <= flags_d;
      mv_start <= start_p;
      mv_abort <= abort_p;
      if (mode_ok) begin
        dir_q <= w_dir;
        sws_q <= w_sws;
        sel_q <= w_sel;
        ext_q <= w_ext;
      end
      if (reg_we && reg_addr == OFF_SRC)  src_q  <= reg_wdata;
      if (reg_we && reg_addr == OFF_DST)  dst_q  <= reg_wdata;
      if (reg_we && reg_addr == OFF_LINK) link_q <= reg_wdata;
      if (reg_we && reg_addr == OFF_LIST) list_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_MODE: reg_rdata = {{(AW-7){1'b0}}, ext_q, sel_q, sws_q, cont_q, dir_q, 1'b0, st_q};
      OFF_STAT: reg_rdata = {{(AW-7){1'b0}}, flags_q, busy_q && !st_q, busy_q};
      OFF_SRC:  reg_rdata = src_q;
      OFF_DST:  reg_rdata = dst_q;
      OFF_LINK: reg_rdata = link_q;
      OFF_LIST: reg_rdata = list_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign mv_run    = busy_q && st_q;
  assign mv_cont   = cont_q;
  assign mv_direct = dir_q;
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign desc_addr = ext_q ? list_q : link_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> busy_q && st_q); // R1
  AST_HALT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mv_done && mode_ok && !w_abort && !w_start |=> busy_q && !mv_run); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_abort |-> !busy_q && !st_q); // R3
  AST_CONT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mv_desc_fetched && !mode_ok |=> !mv_cont); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mv_done |=> !mv_start); // R8
  AST_PERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    perr_req |=> flags_q[1] && !mv_start && $stable(dir_q)); // R9
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mv_err |=> flags_q[0]); // R10
endmodule

// File: tb/dma_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, src_addr, dst_addr, desc_addr;
  logic mv_start, mv_abort, mv_run, mv_cont, mv_direct;
  logic mv_done = 0, mv_desc_fetched = 0, mv_err = 0;
  logic ev_link_end = 0, ev_seg_end = 0, ev_list_end = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_chan_ctrl dut_i (.*);

  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {3'd0, 32'h04,   3'd0, 32'h04},
    {3'd0, 32'h14,   3'd0, 32'h14},
    {3'd0, 32'h34,   3'd0, 32'h34},
    {3'd0, 32'h0C,   3'd1, 32'h08},
    {3'd1, 32'h08,   3'd1, 32'h00},
    {3'd0, 32'h20,   3'd0, 32'h34},
    {3'd1, 32'h08,   3'd1, 32'h00},
    {3'd2, 32'h1000, 3'd1, 32'h01},
    {3'd0, 32'h34,   3'd1, 32'h03},
    {3'd0, 32'h35,   3'd1, 32'h01},
    {3'd0, 32'h36,   3'd0, 32'h34},
    {3'd1, 32'h00,   3'd1, 32'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic done_pulse();
    @(negedge clk); mv_done = 1'b1;
    @(negedge clk); mv_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, 32'h0, "R10 reset status");
    rd(3'd0, 32'h0, "R10 reset mode");
    chk("R10 reset start/run", {mv_start, mv_run}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:67], VEC[i][66:35]);
      rd(VEC[i][34:32], VEC[i][31:0], $sformatf("R4/R9/R2/R3/R6 vector %0d", i));
    end

    wr(3'd0, 32'h01);
    chk("R1 start pulse", {mv_start, mv_run}, 2'b11);
    @(negedge clk);
    chk("R1 pulse one cycle", mv_start, 0);
    done_pulse();
    rd(3'd1, 32'h0, "R1 idle after done");
    rd(3'd0, 32'h0, "R1 start cleared");
    wr(3'd0, 32'h00);
    rd(3'd1, 32'h0, "R2 clear while idle");

    wr(3'd0, 32'h01);
    wr(3'd0, 32'h00);
    chk("R2 halt run low", mv_run, 0);
    rd(3'd1, 32'h03, "R2 halted status");
    wr(3'd0, 32'h01);
    chk("R2 resume no pulse", {mv_start, mv_run}, 2'b01);
    done_pulse();

    wr(3'd0, 32'h02);
    chk("R3 abort idle no pulse", mv_abort, 0);
    rd(3'd1, 32'h0, "R3 abort idle status");
    wr(3'd0, 32'h01);
    wr(3'd0, 32'h03);
    chk("R3 abort pulse", {mv_abort, mv_run}, 2'b10);

    wr(3'd0, 32'h08);
    chk("R5 cont set", mv_cont, 1);
    @(negedge clk); mv_desc_fetched = 1'b1;
    @(negedge clk); mv_desc_fetched = 1'b0;
    chk("R5 cont cleared", mv_cont, 0);

    wr(3'd0, 32'h14);
    chk("R4 direct flag", mv_direct, 1);
    wr(3'd2, 32'hA);
    chk("R6 src no start sel0", mv_start, 0);
    wr(3'd3, 32'hB);
    chk("R6 dst starts sel0", mv_start, 1);
    done_pulse();

    wr(3'd0, 32'h10);
    wr(3'd5, 32'h2000);
    chk("R7 list no start ext0", mv_start, 0);
    wr(3'd4, 32'h2100);
    chk("R7 link starts ext0", mv_start, 1);
    chk("R4 desc link", desc_addr, 32'h2100);
    done_pulse();
    wr(3'd0, 32'h50);
    wr(3'd4, 32'h2200);
    chk("R7 link no start ext1", mv_start, 0);
    wr(3'd5, 32'h3000);
    chk("R7 list starts ext1", mv_start, 1);
    chk("R4 desc list", desc_addr, 32'h3000);
    @(negedge clk);
    wr(3'd5, 32'h4000);
    chk("R8 busy write no start", mv_start, 0);
    rd(3'd1, 32'h01, "R8 still busy");
    chk("R8 addr updated", desc_addr, 32'h4000);
    done_pulse();

    @(negedge clk); mv_err = 1'b1;
    @(negedge clk); mv_err = 1'b0;
    rd(3'd1, 32'h04, "R10 error flag set");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h04; mv_err = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; mv_err = 1'b0;
    rd(3'd1, 32'h04, "R10 set wins over clear");
    wr(3'd1, 32'h04);
    rd(3'd1, 32'h00, "R10 w1c clears");
    @(negedge clk); ev_link_end = 1; ev_seg_end = 1; ev_list_end = 1;
    @(negedge clk); ev_link_end = 0; ev_seg_end = 0; ev_list_end = 0;
    rd(3'd1, 32'h70, "R10 event flags");
    wr(3'd1, 32'h50);
    rd(3'd1, 32'h20, "R10 partial clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule